// File: doc/BRIEF.md
# DMA Burst Length Request Counter

This block sits inside a bus adapter, between one option card and the memory side. It works out how long a DMA burst is. An option card asks for the bus by raising its request line. The block answers with a one-clock grant. In the clock after the grant, it latches the start address and the transfer direction from the option's shared address/data lines. From then on, the option keeps its request raised for one clock per word it wants. The block counts those clocks. No length field exists anywhere: the burst length is simply how long the request stays high. On a write burst, the option also places one data word on the shared lines in each counted clock. The block stores these words in arrival order.

When the request drops, or the count reaches its cap, the block does two things. It emits a one-clock done pulse together with the word count, direction, start address and an overflow flag. It then issues exactly that many word commands on a valid/ready command stream toward memory, so it never fetches or stores more words than were counted.

Back-pressure rules for the command stream:
- `cmd_valid` never depends on `cmd_ready`.
- Once `cmd_valid` is high, the command fields stay unchanged until a clock edge where `cmd_ready` is high; that edge accepts the command.
- `cmd_ready` may stay low for any number of clocks.

Top module: `burst_len_meter`

## Requirements
- R1: After reset, `opt_gnt`, `done`, `cmd_valid` and `len_ovf` are all low.
- R2: A request seen while idle produces a grant exactly one clock wide, and exactly one grant is given per burst.
- R3: The address and direction (`opt_write` = 1 means write, 0 means read) on the option lines in the clock after the grant are latched. They are reported on `len_addr` and `len_write`, and the first command uses that address.
- R4: The word count equals the number of consecutive clocks with the request high, starting in the clock after the address clock. Counting ends at the first clock with the request low.
- R5: `done` is high for exactly one clock per burst. `len_count`, `len_addr`, `len_write` and `len_ovf` are valid while `done` is high and hold until the next grant.
- R6: The count never exceeds MAX_WORDS (default 512). If the request is still high in a clock after MAX_WORDS words were counted, counting stops and `len_ovf` is set. A burst of exactly MAX_WORDS words leaves `len_ovf` low.
- R7: On a write burst, the words driven on the counted clocks are issued in arrival order. Command i carries address start + 4·i and `cmd_write` = 1.
- R8: On a read burst, exactly `len_count` commands are issued, each with `cmd_write` = 0 and `cmd_data` = 0.
- R9: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_addr` and `cmd_data` hold their values into the next clock.
- R10: A burst whose request drops in the first counting clock reports a count of 0 and issues no command.
- R11: The block does not return to idle, and gives no new grant, while the request is still held after a burst ends (for example after an overflow).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_req | input | 1 | Option request; its duration after the address clock encodes the burst length |
| opt_write | input | 1 | Direction, sampled in the address clock (1 = write) |
| opt_ad | input | ADDR_W | Shared address/data lines from the option |
| opt_gnt | output | 1 | One-clock grant to the option |
| cmd_valid | output | 1 | Memory command valid |
| cmd_ready | input | 1 | Memory command ready |
| cmd_addr | output | ADDR_W | Byte address of the command word |
| cmd_data | output | DATA_W | Write data (0 for reads) |
| cmd_write | output | 1 | Command direction |
| done | output | 1 | One-clock pulse when the count is known |
| len_count | output | CNT_W | Counted words |
| len_addr | output | ADDR_W | Latched start address |
| len_write | output | 1 | Latched direction |
| len_ovf | output | 1 | Request outlasted MAX_WORDS |

## Verification
Bursts of 5, 3, 7, 0 and 512 words, plus an over-long request of 1100 clocks, separate a count that stops at the right clock from one that is off by one at either end. They also show where the cap and the overflow flag take effect.

Write bursts carry a distinct word on every counted clock, so lost, repeated or reordered words show up. Read bursts check that exactly the counted number of commands leave the block.

A ready pattern that refuses every third clock checks that command fields hold while stalled. Holding the request long after an overflow checks that no second grant appears.

// File: rtl/blm_pkg.sv
package blm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GRANT,
    ST_ADDR,
    ST_COUNT,
    ST_DONE,
    ST_XFER,
    ST_HOLD
  } blm_state_e;
endpackage

// File: rtl/blm_len_counter.sv
module blm_len_counter #(
  parameter int MAX_WORDS = 512,
  localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             en,
  input  logic             req,
  output logic [CNT_W-1:0] cnt,
  output logic             at_max,
  output logic             ovf
);
  assign at_max = (cnt == CNT_W'(MAX_WORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (clear) begin
      cnt <= '0;
      ovf <= 1'b0;
    end else if (en && req) begin
      if (at_max) ovf <= 1'b1;
      else        cnt <= cnt + 1'b1;
    end
  end

  assert_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(MAX_WORDS)) else $error("count above cap");
  assert_ovf_at_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> at_max) else $error("overflow below cap");
endmodule

// File: rtl/blm_word_buf.sv
module blm_word_buf #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/blm_cmd_issue.sv
module blm_cmd_issue #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 512,
  localparam int CNT_W = $clog2(MAX_WORDS + 1),
  localparam int AW    = $clog2(MAX_WORDS),
  localparam int BSH   = $clog2(DATA_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  len,
  input  logic [ADDR_W-1:0] base,
  input  logic              write,
  output logic [AW-1:0]     rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_write
);
  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && cmd_ready) begin
      if (idx == len - 1'b1) busy <= 1'b0;
      else                   idx  <= idx + 1'b1;
    end
  end

  assign rd_idx    = idx[AW-1:0];
  assign cmd_valid = busy;
  assign cmd_addr  = base + (ADDR_W'(idx) << BSH);
  assign cmd_data  = write ? rd_data : '0;
  assign cmd_write = write;

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_data))
    else $error("command changed while stalled");
  assert_no_excess_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> idx < len) else $error("command beyond counted length");
endmodule

// File: rtl/burst_len_meter.sv
module burst_len_meter #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int MAX_WORDS = 512,
  localparam int CNT_W = $clog2(MAX_WORDS + 1),
  localparam int AW    = $clog2(MAX_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opt_req,
  input  logic              opt_write,
  input  logic [ADDR_W-1:0] opt_ad,
  output logic              opt_gnt,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              cmd_write,
  output logic              done,
  output logic [CNT_W-1:0]  len_count,
  output logic [ADDR_W-1:0] len_addr,
  output logic              len_write,
  output logic              len_ovf
);
  import blm_pkg::*;

  blm_state_e       state, state_nx;
  logic [CNT_W-1:0] cnt;
  logic             at_max;
  logic             busy;
  logic [AW-1:0]    rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic             counting;

  assign counting = (state == ST_COUNT);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (opt_req) state_nx = ST_GRANT;
      ST_GRANT: state_nx = ST_ADDR;
      ST_ADDR:  state_nx = ST_COUNT;
      ST_COUNT: if (!opt_req || at_max) state_nx = ST_DONE;
      ST_DONE:  state_nx = (cnt != '0) ? ST_XFER : ST_HOLD;
      ST_XFER:  if (!busy) state_nx = ST_HOLD;
      ST_HOLD:  if (!opt_req) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      len_addr  <= '0;
      len_write <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == ST_ADDR) begin
        len_addr  <= opt_ad;
        len_write <= opt_write;
      end
    end
  end

  assign opt_gnt   = (state == ST_GRANT);
  assign done      = (state == ST_DONE);
  assign len_count = cnt;

  blm_len_counter #(.MAX_WORDS(MAX_WORDS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(state == ST_ADDR), .en(counting),
    .req(opt_req), .cnt(cnt), .at_max(at_max), .ovf(len_ovf)
  );

  blm_word_buf #(.DATA_W(DATA_W), .DEPTH(MAX_WORDS)) u_buf (
    .clk(clk), .we(counting && opt_req && len_write && !at_max),
    .waddr(cnt[AW-1:0]), .wdata(DATA_W'(opt_ad)),
    .raddr(rd_idx), .rdata(rd_data)
  );

  blm_cmd_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(done && cnt != '0), .len(cnt),
    .base(len_addr), .write(len_write), .rd_idx(rd_idx), .rd_data(rd_data),
    .busy(busy), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_write(cmd_write)
  );

  assert_gnt_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    opt_gnt |=> !opt_gnt) else $error("grant wider than one clock");
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done wider than one clock");
  assert_gnt_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(opt_gnt) |-> $past(opt_req)) else $error("grant without request");
  assert_ovf_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done && len_ovf |-> len_count == CNT_W'(MAX_WORDS)) else $error("overflow below cap");
endmodule

// File: tb/tb_burst_len_meter.sv
module tb_burst_len_meter;
  localparam int MAX = 512;
  localparam int CW  = $clog2(MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic opt_req = 1'b0, opt_write = 1'b0;
  logic [31:0] opt_ad = '0;
  logic opt_gnt, cmd_valid, cmd_ready, cmd_write, done, len_write, len_ovf;
  logic [31:0] cmd_addr, cmd_data, len_addr;
  logic [CW-1:0] len_count;
  bit bp = 1'b0;
  int cyc = 0;

  int n_tests = 0, n_fail = 0;
  int ncmd = 0, done_cnt = 0, gnt_cnt = 0, stab_err = 0;
  logic [31:0] got_addr [2048];
  logic [31:0] got_data [2048];
  logic        got_wr   [2048];
  logic [CW-1:0] d_count;
  logic [31:0]   d_addr;
  logic          d_write, d_ovf;
  bit prev_stall = 1'b0;
  logic [31:0] prev_addr, prev_data;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign cmd_ready = bp ? (cyc % 3 != 0) : 1'b1;

  burst_len_meter dut (
    .clk(clk), .rst_n(rst_n), .opt_req(opt_req), .opt_write(opt_write), .opt_ad(opt_ad),
    .opt_gnt(opt_gnt), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .cmd_write(cmd_write), .done(done), .len_count(len_count),
    .len_addr(len_addr), .len_write(len_write), .len_ovf(len_ovf)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && !(cmd_valid && cmd_addr == prev_addr && cmd_data == prev_data))
        stab_err++;
      prev_stall = cmd_valid && !cmd_ready;
      prev_addr  = cmd_addr;
      prev_data  = cmd_data;
      if (cmd_valid && cmd_ready) begin
        got_addr[ncmd % 2048] = cmd_addr;
        got_data[ncmd % 2048] = cmd_data;
        got_wr[ncmd % 2048]   = cmd_write;
        ncmd++;
      end
      if (done) begin
        done_cnt++;
        d_count = len_count; d_addr = len_addr; d_write = len_write; d_ovf = len_ovf;
      end
      if (opt_gnt) gnt_cnt++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [31:0] a, input int i);
    return a ^ (32'h9E3779B9 * 32'(i + 1));
  endfunction

  task automatic t_reset;
    chk(opt_gnt == 1'b0, "R1 gnt", opt_gnt, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
    chk(len_ovf == 1'b0, "R1 ovf", len_ovf, 0);
  endtask

  task automatic run_burst(input string name, input logic [31:0] addr, input bit wr,
                           input int n, input bit use_bp);
    int d0, c0, g0, s0, expn, bad_a, bad_d, bad_w;
    expn = (n > MAX) ? MAX : n;
    @(negedge clk); bp = use_bp; opt_req = 1'b0;
    @(negedge clk);
    d0 = done_cnt; c0 = ncmd; g0 = gnt_cnt; s0 = stab_err;
    opt_req = 1'b1;
    do @(negedge clk); while (!opt_gnt);
    opt_ad = addr; opt_write = wr;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      opt_ad = word(addr, i);
      opt_req = 1'b1;
    end
    @(negedge clk);
    opt_req = 1'b0; opt_ad = '0;
    for (int t = 0; t < 3000 && !(done_cnt > d0 && ncmd - c0 >= expn); t++) @(negedge clk);
    repeat (5) @(negedge clk);
    $display("[TB] scenario %s", name);
    chk(done_cnt - d0 == 1, "R5 single done", done_cnt - d0, 1);
    chk(d_count == CW'(expn), "R4 counted length", d_count, expn);
    chk(d_addr == addr, "R3 latched address", d_addr, addr);
    chk(d_write == wr, "R3 latched direction", d_write, wr);
    chk(d_ovf == (n > MAX), "R6 overflow flag", d_ovf, n > MAX);
    chk(ncmd - c0 == expn, "R8 R10 command count", ncmd - c0, expn);
    chk(gnt_cnt - g0 == 1, "R2 R11 grant count", gnt_cnt - g0, 1);
    chk(stab_err == s0, "R9 stall stability", stab_err - s0, 0);
    bad_a = 0; bad_d = 0; bad_w = 0;
    for (int i = 0; i < expn && i < ncmd - c0; i++) begin
      if (got_addr[(c0 + i) % 2048] != addr + 32'(4 * i)) bad_a++;
      if (got_wr[(c0 + i) % 2048] != wr) bad_w++;
      if (got_data[(c0 + i) % 2048] != (wr ? word(addr, i) : 32'h0)) bad_d++;
    end
    chk(bad_a == 0, "R7 command addresses", bad_a, 0);
    chk(bad_w == 0, "R7 R8 command direction", bad_w, 0);
    chk(bad_d == 0, wr ? "R7 write data order" : "R8 read data zero", bad_d, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_burst("write5",   32'h0000_1000, 1'b1, 5, 1'b0);
    run_burst("read3_bp", 32'h0002_0200, 1'b0, 3, 1'b1);
    run_burst("write7_bp",32'h0003_0400, 1'b1, 7, 1'b1);
    run_burst("zero_R10", 32'h0004_0000, 1'b1, 0, 1'b0);
    run_burst("write_max",32'h0010_0000, 1'b1, MAX, 1'b0);
    run_burst("read_ovf_R11", 32'h0020_0000, 1'b0, 1100, 1'b0);
    run_burst("write2",   32'h0030_0010, 1'b1, 2, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule